// File: doc/BRIEF.md
# Merging Write Pool with Partial-Line Completion

This block parks memory write packets after the host side has handed them over and before a downstream scheduler writes them to memory. Each packet carries a line address, a full line of data and a per-byte enable mask. A write to an address that already sits in the pool does not take a second slot. It folds into the existing entry: the bytes it enables replace the stored ones, and its mask is ORed into the entry's mask. The requester gets its acknowledge as soon as the packet is taken in, so the pool must keep every later read and drain consistent with writes it has already acknowledged.

The memory behind the pool cannot write part of a line. A line with only some bytes enabled is completed by read-modify-write. The pool asks for the line to be read, with the entry index as the tag. When the line comes back, it copies in only the bytes that no write has covered so far. Writes that are merged after the read request has left still win over the returning line, byte by byte. This holds even when the merge and the return land in the same cycle. The drain port shows only full lines, oldest allocation first.

Top module: `wcp_pool`

## Requirements
- R1: A write whose address matches a held entry merges into that entry and takes no new slot. Each address is drained exactly once with the merged result.
- R2: In a merge, each byte whose enable bit is set takes the new write's byte. Every other byte keeps its stored value. The entry mask becomes the OR of both masks (bit b covers data bits 8b+7..8b).
- R3: A write allocated with an all-ones mask is drainable at once and raises no line-read request.
- R4: An entry with a partial mask raises `rd_req_valid` with its address and its entry index on `rd_req_tag`. After the handshake, that entry asks no more.
- R5: A line returned on `rd_rsp_*` for a waiting entry fills only bytes whose mask bit is clear. The entry then becomes drainable. The entry is not drainable while its read is outstanding.
- R6: Bytes written into an entry while its line read is outstanding, including in the same cycle as the return, are kept over the returned line.
- R7: If a merge makes the mask all ones while a read is outstanding, the entry still waits for the return. The return then changes no data.
- R8: `wr_ack` is high for exactly the one cycle after each accepted write (`wr_valid` and `wr_ready` both high), and low otherwise.
- R9: `wr_ready` is low when no entry matches and no entry is free. A write that matches a held entry is still accepted when the pool is full.
- R10: A write whose address matches the entry being drained in the same cycle sees `wr_ready` low for that cycle. It is then accepted as a new entry.
- R11: Entries drain in allocation order. The oldest entry blocks younger ready entries until it is drainable. While `drn_ready` is low, the shown line is held.
- R12: After reset, `wr_ready` is high, `wr_ack`, `rd_req_valid` and `drn_valid` are low, and the pool is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Incoming write present |
| wr_ready | output | 1 | Pool can take the write this cycle |
| wr_addr | input | AW | Line address of the write |
| wr_data | input | 8*NB | Line data of the write |
| wr_be | input | NB | Byte enables of the write |
| wr_ack | output | 1 | Registered acknowledge of an accepted write |
| rd_req_valid | output | 1 | Line read wanted for a partial entry |
| rd_req_ready | input | 1 | Line read request taken |
| rd_req_addr | output | AW | Address of the line to read |
| rd_req_tag | output | IW | Entry index sent with the read |
| rd_rsp_valid | input | 1 | Returned line present |
| rd_rsp_tag | input | IW | Entry index of the returned line |
| rd_rsp_data | input | 8*NB | Returned line data |
| drn_valid | output | 1 | Oldest entry holds a full line ready to write |
| drn_ready | input | 1 | Scheduler takes the line |
| drn_addr | output | AW | Address of the drained line |
| drn_data | output | 8*NB | Full line data to write |

## Verification
The hard collision is a merging write and the returning line for the same entry in the same cycle. The bench provokes it by putting both on the ports at one falling edge, for every pair of first and second byte masks. The bench then drains the line and compares each byte with a per-byte choice: second write first, then first write, then the returned line. A second collision is a write to the entry that is being drained. The bench checks that `wr_ready` drops for exactly that cycle, that no acknowledge follows it, and that the retried write comes out later as a fresh line.

// File: rtl/wcp_pkg.sv
package wcp_pkg;
  typedef enum logic [1:0] {
    ST_FREE   = 2'd0,
    ST_PART   = 2'd1,
    ST_RDWAIT = 2'd2,
    ST_READY  = 2'd3
  } ent_st_t;
endpackage

// File: rtl/wcp_pick.sv
// Lowest-index first-set finder.
module wcp_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/wcp_match.sv
// Address compare across all held entries.
module wcp_match #(
  parameter int N  = 8,
  parameter int AW = 12,
  parameter int IW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        vld,
  input  logic [N-1:0][AW-1:0] tags,
  input  logic [AW-1:0]       key,
  output logic                hit,
  output logic [IW-1:0]       hit_idx
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = vld[g] && (tags[g] == key);
  end

  wcp_pick #(.N(N), .IW(IW)) u_pick (
    .req   (eq),
    .found (hit),
    .idx   (hit_idx)
  );

  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (rst) $onehot0(eq)); // R1
endmodule

// File: rtl/wcp_age.sv
// Allocation-age tracking; the oldest held entry has the largest age.
module wcp_age #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_en,
  input  logic [IW-1:0] alloc_idx,
  input  logic [N-1:0]  vld,
  output logic          oldest_ok,
  output logic [IW-1:0] oldest_idx
);
  logic [IW-1:0] age [N];
  logic [IW-1:0] best;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age[i] <= '0;
    end else if (alloc_en) begin
      for (int i = 0; i < N; i++) begin
        if (alloc_idx == IW'(i)) age[i] <= '0;
        else if (vld[i])         age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_ok  = 1'b0;
    oldest_idx = '0;
    best       = '0;
    for (int i = 0; i < N; i++) begin
      if (vld[i] && (!oldest_ok || age[i] > best)) begin
        oldest_ok  = 1'b1;
        oldest_idx = IW'(i);
        best       = age[i];
      end
    end
  end

  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> !vld[alloc_idx]); // R1
endmodule

// File: rtl/wcp_merge.sv
// Per-byte merge: write bytes first, then returned-line fill of uncovered bytes.
module wcp_merge #(
  parameter int NB = 4,
  localparam int DW = NB * 8
) (
  input  logic [DW-1:0] base_d,
  input  logic [NB-1:0] base_m,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_d,
  input  logic [NB-1:0] wr_m,
  input  logic          fill_en,
  input  logic [DW-1:0] fill_d,
  output logic [DW-1:0] new_d,
  output logic [NB-1:0] new_m
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic       wb;
    logic       cov;
    logic [7:0] mid;
    assign wb  = wr_en && wr_m[b];
    assign cov = base_m[b] || wb;
    assign mid = wb ? wr_d[8*b +: 8] : base_d[8*b +: 8];
    assign new_d[8*b +: 8] = (fill_en && !cov) ? fill_d[8*b +: 8] : mid;
    assign new_m[b] = cov || fill_en;
  end
endmodule

// File: rtl/wcp_pool.sv
module wcp_pool
  import wcp_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 12,
  parameter int NB = 4,
  localparam int IW = $clog2(N),
  localparam int DW = NB * 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [NB-1:0] wr_be,
  output logic          wr_ack,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  output logic [IW-1:0] rd_req_tag,
  input  logic          rd_rsp_valid,
  input  logic [IW-1:0] rd_rsp_tag,
  input  logic [DW-1:0] rd_rsp_data,
  output logic          drn_valid,
  input  logic          drn_ready,
  output logic [AW-1:0] drn_addr,
  output logic [DW-1:0] drn_data
);
  ent_st_t              st  [N];
  logic [N-1:0][AW-1:0] tag;
  logic [DW-1:0]        dat [N];
  logic [NB-1:0]        msk [N];

  logic [N-1:0] vld, free_v, part_v, w_sel, f_sel;
  logic [DW-1:0] nd [N];
  logic [NB-1:0] nm [N];

  logic          hit, free_ok, part_ok, oldest_ok;
  logic [IW-1:0] hit_idx, free_idx, part_idx, oldest_idx, wr_tgt;
  logic          drn_fire, rd_fire, wr_fire, alloc, fill_ok;

  for (genvar g = 0; g < N; g++) begin : g_flags
    assign vld[g]    = (st[g] != ST_FREE);
    assign free_v[g] = (st[g] == ST_FREE);
    assign part_v[g] = (st[g] == ST_PART);
  end

  wcp_match #(.N(N), .AW(AW), .IW(IW)) u_match (
    .clk (clk), .rst (rst), .vld (vld), .tags (tag), .key (wr_addr),
    .hit (hit), .hit_idx (hit_idx)
  );

  wcp_pick #(.N(N), .IW(IW)) u_free (.req (free_v), .found (free_ok), .idx (free_idx));
  wcp_pick #(.N(N), .IW(IW)) u_part (.req (part_v), .found (part_ok), .idx (part_idx));

  wcp_age #(.N(N), .IW(IW)) u_age (
    .clk (clk), .rst (rst), .alloc_en (alloc), .alloc_idx (free_idx), .vld (vld),
    .oldest_ok (oldest_ok), .oldest_idx (oldest_idx)
  );

  // Drain side: only the oldest entry, and only once it holds a full line.
  assign drn_valid = oldest_ok && (st[oldest_idx] == ST_READY);
  assign drn_addr  = tag[oldest_idx];
  assign drn_data  = dat[oldest_idx];
  assign drn_fire  = drn_valid && drn_ready;

  // Line-read requests for partial entries.
  assign rd_req_valid = part_ok;
  assign rd_req_addr  = tag[part_idx];
  assign rd_req_tag   = part_idx;
  assign rd_fire      = rd_req_valid && rd_req_ready;

  // Acceptance: merge on a hit unless that entry leaves this cycle; else allocate.
  assign wr_ready = hit ? !(drn_fire && (hit_idx == oldest_idx)) : free_ok;
  assign wr_fire  = wr_valid && wr_ready;
  assign wr_tgt   = hit ? hit_idx : free_idx;
  assign alloc    = wr_fire && !hit;
  assign fill_ok  = rd_rsp_valid && (st[rd_rsp_tag] == ST_RDWAIT);

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [NB-1:0] base_m;
    assign w_sel[g] = wr_fire && (wr_tgt == IW'(g));
    assign f_sel[g] = fill_ok && (rd_rsp_tag == IW'(g));
    assign base_m   = (alloc && w_sel[g]) ? '0 : msk[g];

    wcp_merge #(.NB(NB)) u_merge (
      .base_d  (dat[g]),
      .base_m  (base_m),
      .wr_en   (w_sel[g]),
      .wr_d    (wr_data),
      .wr_m    (wr_be),
      .fill_en (f_sel[g]),
      .fill_d  (rd_rsp_data),
      .new_d   (nd[g]),
      .new_m   (nm[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        st[i]  <= ST_FREE;
        msk[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (drn_fire && (oldest_idx == IW'(i))) begin
          st[i] <= ST_FREE;
        end else begin
          if (w_sel[i] || f_sel[i]) msk[i] <= nm[i];
          if (rd_fire && (part_idx == IW'(i)))
            st[i] <= ST_RDWAIT;
          else if (f_sel[i])
            st[i] <= ST_READY;
          else if (w_sel[i] && (st[i] == ST_FREE || st[i] == ST_PART))
            st[i] <= (&nm[i]) ? ST_READY : ST_PART;
        end
      end
    end
  end

  // Payload storage carries no reset.
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (w_sel[i] || f_sel[i]) dat[i] <= nd[i];
      if (w_sel[i] && alloc)    tag[i] <= wr_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wr_ack <= 1'b0;
    else     wr_ack <= wr_fire;
  end

  AST_ACK_AFTER: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> wr_ack); // R8
  AST_ACK_ONLY: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid && wr_ready) |=> !wr_ack); // R8
  AST_RSP_WAITING: assert property (@(posedge clk) disable iff (rst)
    rd_rsp_valid |-> (st[rd_rsp_tag] == ST_RDWAIT)); // R5
  AST_FILL_DONE: assert property (@(posedge clk) disable iff (rst)
    fill_ok |=> (st[$past(rd_rsp_tag)] == ST_READY)); // R5
  AST_DRAIN_FULL: assert property (@(posedge clk) disable iff (rst)
    drn_valid |-> (&msk[oldest_idx])); // R7
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (drn_valid && !drn_ready) |=> (drn_valid && $stable(drn_addr))); // R11
endmodule

// File: tb/tb_wcp_pool.sv
`timescale 1ns/1ps
module tb_wcp_pool;
  localparam int N  = 8;
  localparam int AW = 12;
  localparam int NB = 4;
  localparam int IW = 3;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst;
  logic wr_valid, wr_ready, wr_ack;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [NB-1:0] wr_be;
  logic rd_req_valid, rd_req_ready;
  logic [AW-1:0] rd_req_addr;
  logic [IW-1:0] rd_req_tag;
  logic rd_rsp_valid;
  logic [IW-1:0] rd_rsp_tag;
  logic [DW-1:0] rd_rsp_data;
  logic drn_valid, drn_ready;
  logic [AW-1:0] drn_addr;
  logic [DW-1:0] drn_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wcp_pool #(.N(N), .AW(AW), .NB(NB)) dut (
    .clk (clk), .rst (rst),
    .wr_valid (wr_valid), .wr_ready (wr_ready), .wr_addr (wr_addr),
    .wr_data (wr_data), .wr_be (wr_be), .wr_ack (wr_ack),
    .rd_req_valid (rd_req_valid), .rd_req_ready (rd_req_ready),
    .rd_req_addr (rd_req_addr), .rd_req_tag (rd_req_tag),
    .rd_rsp_valid (rd_rsp_valid), .rd_rsp_tag (rd_rsp_tag), .rd_rsp_data (rd_rsp_data),
    .drn_valid (drn_valid), .drn_ready (drn_ready),
    .drn_addr (drn_addr), .drn_data (drn_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] blend(input logic [3:0] m2, input logic [31:0] d2,
                                        input logic [3:0] m1, input logic [31:0] d1,
                                        input logic [31:0] r);
    logic [31:0] o;
    for (int b = 0; b < 4; b++)
      o[8*b +: 8] = m2[b] ? d2[8*b +: 8] : (m1[b] ? d1[8*b +: 8] : r[8*b +: 8]);
    return o;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] m);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be = m;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    #1 chk(wr_ack == 1'b1, "R8 ack", 32'(wr_ack), 32'd1);
  endtask

  task automatic rd_take(input logic [AW-1:0] a, output logic [IW-1:0] t);
    @(negedge clk); #1;
    chk(rd_req_valid == 1'b1, "R4 req valid", 32'(rd_req_valid), 32'd1);
    chk(rd_req_addr == a, "R4 req addr", 32'(rd_req_addr), 32'(a));
    t = rd_req_tag;
    rd_req_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_req_ready = 1'b0;
    #1 chk(rd_req_valid == 1'b0, "R4 req drops", 32'(rd_req_valid), 32'd0);
  endtask

  task automatic ret(input logic [IW-1:0] t, input logic [DW-1:0] d);
    @(negedge clk);
    rd_rsp_valid = 1'b1; rd_rsp_tag = t; rd_rsp_data = d;
    @(posedge clk);
    @(negedge clk);
    rd_rsp_valid = 1'b0;
  endtask

  task automatic drain(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    @(negedge clk); #1;
    chk(drn_valid == 1'b1, req, 32'(drn_valid), 32'd1);
    chk(drn_addr == a, req, 32'(drn_addr), 32'(a));
    chk(drn_data == d, req, drn_data, d);
    drn_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    drn_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [IW-1:0] t;
    logic [AW-1:0] a;
    logic [DW-1:0] d1, d2, r;
    rst = 1'b1;
    wr_valid = 0; wr_addr = 0; wr_data = 0; wr_be = 0;
    rd_req_ready = 0; rd_rsp_valid = 0; rd_rsp_tag = 0; rd_rsp_data = 0; drn_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R12 reset state
    chk(wr_ready == 1'b1, "R12 ready", 32'(wr_ready), 32'd1);
    chk(wr_ack == 1'b0, "R12 ack", 32'(wr_ack), 32'd0);
    chk(rd_req_valid == 1'b0, "R12 req", 32'(rd_req_valid), 32'd0);
    chk(drn_valid == 1'b0, "R12 drain", 32'(drn_valid), 32'd0);

    // Sweep of first/second masks: merge before return, or in the same cycle (R2 R5 R6 R7)
    for (int b1 = 1; b1 < 16; b1++) begin
      for (int b2 = 0; b2 < 16; b2++) begin
        for (int md = 0; md < 2; md++) begin
          if (b1 == 15 && md == 1) continue;
          a  = AW'(b1 * 64 + b2 * 2 + md);
          d1 = 32'hA1A2A3A4 ^ {4{4'(b1), 4'(b2)}};
          d2 = 32'hB5B6B7B8 ^ {4{4'(b2), 4'(b1)}};
          r  = 32'hC9CACBCC ^ {4{7'(b1), 1'(md)}};
          wr(a, d1, 4'(b1));
          if (b1 == 15) begin
            #1 chk(rd_req_valid == 1'b0, "R3 no read", 32'(rd_req_valid), 32'd0);
            wr(a, d2, 4'(b2));
            drain(a, blend(4'(b2), d2, 4'(b1), d1, r), "R2 full merge");
          end else begin
            rd_take(a, t);
            if (md == 0) begin
              wr(a, d2, 4'(b2));
              #1 chk(drn_valid == 1'b0, "R7 waits for return", 32'(drn_valid), 32'd0);
              ret(t, r);
              drain(a, blend(4'(b2), d2, 4'(b1), d1, r), "R6 merge before return");
            end else begin
              @(negedge clk);
              wr_valid = 1'b1; wr_addr = a; wr_data = d2; wr_be = 4'(b2);
              rd_rsp_valid = 1'b1; rd_rsp_tag = t; rd_rsp_data = r;
              #1 chk(wr_ready == 1'b1, "R6 same-cycle accept", 32'(wr_ready), 32'd1);
              @(posedge clk);
              @(negedge clk);
              wr_valid = 1'b0; rd_rsp_valid = 1'b0;
              #1 chk(wr_ack == 1'b1, "R8 ack same cycle", 32'(wr_ack), 32'd1);
              drain(a, blend(4'(b2), d2, 4'(b1), d1, r), "R6 same-cycle merge");
            end
          end
          #1 chk(drn_valid == 1'b0, "R1 single drain", 32'(drn_valid), 32'd0);
        end
      end
    end

    // Fill the pool with full lines (R9), merge into a held one, drain in order (R11 R1)
    for (int i = 0; i < N; i++) wr(AW'(12'h100 + i), 32'h10000000 * i + 32'h55, 4'hF);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 12'h3FF; wr_data = 32'h0; wr_be = 4'hF;
    #1 chk(wr_ready == 1'b0, "R9 full stalls", 32'(wr_ready), 32'd0);
    @(negedge clk);
    wr_valid = 1'b0;
    #1 chk(wr_ack == 1'b0, "R8 no ack on stall", 32'(wr_ack), 32'd0);
    wr(12'h103, 32'hEE00EE00, 4'b0101);
    for (int i = 0; i < N; i++) begin
      d1 = 32'h10000000 * i + 32'h55;
      if (i == 3) d1 = blend(4'b0101, 32'hEE00EE00, 4'hF, d1, 32'h0);
      drain(AW'(12'h100 + i), d1, "R11 order");
    end
    #1 chk(drn_valid == 1'b0, "R1 pool empty", 32'(drn_valid), 32'd0);

    // Head-of-line blocking (R11): partial oldest holds back a ready younger entry
    wr(12'h200, 32'h11223344, 4'b0011);
    wr(12'h201, 32'h55667788, 4'hF);
    #1 chk(drn_valid == 1'b0, "R11 head blocks", 32'(drn_valid), 32'd0);
    rd_take(12'h200, t);
    ret(t, 32'hAABBCCDD);
    drain(12'h200, 32'hAABB3344, "R5 fill");
    drain(12'h201, 32'h55667788, "R11 younger");

    // Write colliding with a drain of the same entry (R10)
    wr(12'h300, 32'h01020304, 4'hF);
    @(negedge clk);
    drn_ready = 1'b1;
    wr_valid = 1'b1; wr_addr = 12'h300; wr_data = 32'h0A0B0C0D; wr_be = 4'hF;
    #1;
    chk(wr_ready == 1'b0, "R10 stall", 32'(wr_ready), 32'd0);
    chk(drn_data == 32'h01020304, "R10 old line", drn_data, 32'h01020304);
    @(posedge clk);
    @(negedge clk);
    drn_ready = 1'b0;
    #1;
    chk(wr_ack == 1'b0, "R10 no ack", 32'(wr_ack), 32'd0);
    chk(wr_ready == 1'b1, "R10 retry", 32'(wr_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    #1 chk(wr_ack == 1'b1, "R8 ack retry", 32'(wr_ack), 32'd1);
    drain(12'h300, 32'h0A0B0C0D, "R10 new entry");
    #1 chk(drn_valid == 1'b0, "R10 empty", 32'(drn_valid), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule